// File: doc/BRIEF.md
# Multi-Bank External Bus Controller

This block converts internal read and write requests into timed cycles on an asynchronous external bus that serves SRAM, ROM and memory-mapped peripheral devices. Each request address is compared against up to eight programmable bank windows. The first enabled bank that matches decides the data width, the strobe timing and the fill order of the cycle. The block drives a one-hot chip select, output enable, write enable, byte enables, the byte address and the write data. It samples returned data from the bus.

A bank runs on a fixed count of wait states, or it holds the strobe until the device raises its ready line. A 32-bit access to a 16-bit bank is split into two half-word cycles, and the two halves are merged into one response. A read marked as a burst performs an eight-word line fill. The fill order is either sequential from word zero or starts at the requested word and wraps, as set per bank. A request that matches no bank returns an error and does not touch the bus.

Top module: `extbus_ctrl`

## Requirements
- R1: A bank is programmed by writing a 23-bit word to `cfgWdata` with `cfgSel` naming the bank. The fields are: bit 0 enable, bit 1 width (1 = 32-bit, 0 = 16-bit), bit 2 ready-paced, bit 3 critical-word-first, bits 7:4 wait count, bits 14:8 base, bits 22:16 mask. A bank matches when it is enabled and (byte address bits 26:20 AND mask) equals (base AND mask). When several banks match, the lowest index wins, and only that bank's `busCs` bit is raised.
- R2: A request that matches no enabled bank is answered one cycle after acceptance with `rspValid`, `rspErr` and `rspLast` all high. No chip select is driven.
- R3: On a fixed-wait bank, each bus cycle holds its strobe for wait count + 1 clock cycles. The response appears in the cycle after the last strobe cycle.
- R4: On a ready-paced bank, the strobe is held until `busReady` is sampled high at a clock edge. If ready has not arrived after 256 strobe cycles, the access ends with an error response.
- R5: On a 16-bit bank, an access makes two half-word cycles. The low half comes first at byte offset 0, then the high half at offset 2. Data travels on lanes 15:0, and byte enables follow `reqBe[1:0]` and then `reqBe[3:2]` on `busBe[1:0]`. The read data is returned as {second half, first half}.
- R6: On a 32-bit bank, a single access makes one bus cycle. `busBe` equals `reqBe`, `busDout` equals `reqWdata`, and the read response carries `busDin` as sampled.
- R7: A burst read in sequential mode performs eight bus cycles at words 0 to 7 of the 32-byte line and returns eight responses, with `rspLast` only on the eighth. A write with the burst flag set is performed as a single transfer.
- R8: A burst read in critical-word-first mode starts at the requested word and wraps modulo eight.
- R9: `busOe` is raised only for reads and `busWe` only for writes. The two are never high together, and neither is high without a chip select.
- R10: `reqReady` is high only while no bus cycle is in progress. A request is accepted on a clock edge where `reqValid` and `reqReady` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Bank configuration write strobe |
| cfgSel | input | 3 | Bank index for the configuration write |
| cfgWdata | input | 23 | Bank configuration word |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBurst | input | 1 | Line fill (reads only) |
| reqAddr | input | 25 | Word address (byte address bits 26:2) |
| reqBe | input | 4 | Byte enables |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Response valid, one per word |
| rspErr | output | 1 | Error response |
| rspLast | output | 1 | Final response of the request |
| rspData | output | 32 | Read data |
| busCs | output | 8 | Per-bank chip select, active high |
| busOe | output | 1 | Output enable |
| busWe | output | 1 | Write enable |
| busBe | output | 4 | Byte enables |
| busAddr | output | 27 | Byte address |
| busDout | output | 32 | Write data to the devices |
| busDin | input | 32 | Read data from the devices |
| busReady | input | 1 | Device-paced ready |

## Verification
The ready timeout is the hardest case to reach from the ports. It needs a paced bank and a device that never answers, and the strobe must then stay up for 256 cycles. The bench's device model raises ready after a programmable number of strobe cycles. Setting that number far beyond the limit drives the controller into the timeout. The same model with small delays covers normal paced transfers. The wrap of a critical-word-first fill is reached by starting a burst in the upper half of the line and checking the order of the returned addresses.

// File: rtl/extbus_pkg.sv
package extbus_pkg;
  localparam int LINE_WORDS = 8;
  localparam int BEAT_W     = $clog2(LINE_WORDS);
  localparam int WIN_W      = 7;
  localparam int WAIT_W     = 4;
  localparam int CFG_W      = 2 * WIN_W + WAIT_W + 5;

  typedef struct packed {
    logic [WIN_W-1:0]  mask;
    logic [WIN_W-1:0]  base;
    logic [WAIT_W-1:0] waits;
    logic              critFirst;
    logic              paced;
    logic              wide;
    logic              en;
  } bankCfg_t;

  typedef struct packed {
    logic              load;
    logic              capLo;
    logic              capHi;
    logic              capWord;
    logic              half;
    logic [BEAT_W-1:0] beat;
    logic              wide;
    logic              critFirst;
    logic              burst;
  } dpCtl_t;

  function automatic bankCfg_t unpackCfg(input logic [CFG_W-1:0] w);
    bankCfg_t c;
    c.en        = w[0];
    c.wide      = w[1];
    c.paced     = w[2];
    c.critFirst = w[3];
    c.waits     = w[7:4];
    c.base      = w[8 +: WIN_W];
    c.mask      = w[16 +: WIN_W];
    return c;
  endfunction
endpackage

// File: rtl/extbus_ctl.sv
module extbus_ctl
  import extbus_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int TIMEOUT   = 256
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgWe,
  input  logic [$clog2(NUM_BANKS)-1:0] cfgSel,
  input  logic [CFG_W-1:0]             cfgWdata,
  input  logic                         reqValid,
  input  logic                         reqWrite,
  input  logic                         reqBurst,
  input  logic [WIN_W-1:0]             reqWin,
  input  logic                         busReady,
  output logic                         reqReady,
  output logic                         rspValid,
  output logic                         rspErr,
  output logic                         rspLast,
  output logic [NUM_BANKS-1:0]         busCs,
  output logic                         busOe,
  output logic                         busWe,
  output dpCtl_t                       dpCtl
);
  localparam int SEL_W = $clog2(NUM_BANKS);
  localparam int CNT_W = $clog2(TIMEOUT);

  typedef enum logic {S_IDLE, S_STROBE} state_t;

  state_t            state;
  bankCfg_t          cfg [NUM_BANKS];
  logic [CNT_W-1:0]  cnt;
  logic [BEAT_W-1:0] beat;
  logic              half, isWrite, isBurst;
  logic              curWide, curPaced, curCrit;
  logic [WAIT_W-1:0] curWaits;
  logic [SEL_W-1:0]  bankSel, hitIdx;
  logic              hit, stepDone, timedOut, needHi, lastBeat, capture;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN)                                    cfg[i] <= '0;
      else if (cfgWe && cfgSel == SEL_W'(i))        cfg[i] <= unpackCfg(cfgWdata);
    end
    assign busCs[i] = (state == S_STROBE) && (bankSel == SEL_W'(i));
  end

  // Lowest index wins: scan downward so the last hit kept is the smallest.
  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (cfg[i].en && ((reqWin & cfg[i].mask) == (cfg[i].base & cfg[i].mask))) begin
        hit    = 1'b1;
        hitIdx = SEL_W'(i);
      end
    end
  end

  assign stepDone = curPaced ? busReady : (cnt == CNT_W'(curWaits));
  assign timedOut = curPaced && !busReady && (cnt == CNT_W'(TIMEOUT - 1));
  assign needHi   = !curWide && !half;
  assign lastBeat = !isBurst || (beat == BEAT_W'(LINE_WORDS - 1));
  assign capture  = (state == S_STROBE) && stepDone;

  assign reqReady = (state == S_IDLE);
  assign busOe    = (state == S_STROBE) && !isWrite;
  assign busWe    = (state == S_STROBE) && isWrite;

  always_comb begin
    dpCtl           = '0;
    dpCtl.load      = reqReady && reqValid;
    dpCtl.capWord   = capture && curWide;
    dpCtl.capLo     = capture && !curWide && !half;
    dpCtl.capHi     = capture && !curWide && half;
    dpCtl.half      = half;
    dpCtl.beat      = beat;
    dpCtl.wide      = curWide;
    dpCtl.critFirst = curCrit;
    dpCtl.burst     = isBurst;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      beat     <= '0;
      half     <= 1'b0;
      isWrite  <= 1'b0;
      isBurst  <= 1'b0;
      curWide  <= 1'b0;
      curPaced <= 1'b0;
      curCrit  <= 1'b0;
      curWaits <= '0;
      bankSel  <= '0;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspLast  <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspLast  <= 1'b0;
      case (state)
        S_IDLE: if (reqValid) begin
          if (hit) begin
            state    <= S_STROBE;
            bankSel  <= hitIdx;
            curWide  <= cfg[hitIdx].wide;
            curPaced <= cfg[hitIdx].paced;
            curCrit  <= cfg[hitIdx].critFirst;
            curWaits <= cfg[hitIdx].waits;
            isWrite  <= reqWrite;
            isBurst  <= reqBurst && !reqWrite;
            cnt      <= '0;
            beat     <= '0;
            half     <= 1'b0;
          end else begin
            rspValid <= 1'b1;
            rspErr   <= 1'b1;
            rspLast  <= 1'b1;
          end
        end
        S_STROBE: begin
          if (timedOut) begin
            rspValid <= 1'b1;
            rspErr   <= 1'b1;
            rspLast  <= 1'b1;
            state    <= S_IDLE;
          end else if (stepDone) begin
            cnt <= '0;
            if (needHi) begin
              half <= 1'b1;
            end else begin
              half     <= 1'b0;
              rspValid <= 1'b1;
              rspLast  <= lastBeat;
              if (lastBeat) state <= S_IDLE;
              else          beat  <= beat + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/extbus_dp.sv
module extbus_dp
  import extbus_pkg::*;
#(
  parameter int ADDR_W = 27
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [ADDR_W-3:0] reqAddr,
  input  logic [3:0]        reqBe,
  input  logic [31:0]       reqWdata,
  input  logic [31:0]       busDin,
  output logic [ADDR_W-1:0] busAddr,
  output logic [3:0]        busBe,
  output logic [31:0]       busDout,
  output logic [31:0]       rspData
);
  localparam int OFF_W = BEAT_W + 2;

  logic [ADDR_W-3:0] addrQ;
  logic [3:0]        beQ;
  logic [31:0]       wdataQ, dataQ;
  logic [BEAT_W-1:0] startWord, wordIdx;

  assign startWord = addrQ[BEAT_W-1:0];
  assign wordIdx   = (dpCtl.burst && !dpCtl.critFirst) ? dpCtl.beat : startWord + dpCtl.beat;
  assign busAddr   = {addrQ[ADDR_W-3:BEAT_W], wordIdx, dpCtl.wide ? 1'b0 : dpCtl.half, 1'b0};
  assign busBe     = dpCtl.wide ? beQ : {2'b00, dpCtl.half ? beQ[3:2] : beQ[1:0]};
  assign busDout   = dpCtl.wide ? wdataQ : {16'h0000, dpCtl.half ? wdataQ[31:16] : wdataQ[15:0]};
  assign rspData   = dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      beQ    <= '0;
      wdataQ <= '0;
      dataQ  <= '0;
    end else begin
      if (dpCtl.load) begin
        addrQ  <= reqAddr;
        beQ    <= reqBe;
        wdataQ <= reqWdata;
      end
      if (dpCtl.capWord) dataQ         <= busDin;
      if (dpCtl.capLo)   dataQ[15:0]   <= busDin[15:0];
      if (dpCtl.capHi)   dataQ[31:16]  <= busDin[15:0];
    end
  end
endmodule

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
  import extbus_pkg::*;
#(
  parameter int ADDR_W    = 27,
  parameter int NUM_BANKS = 8,
  parameter int TIMEOUT   = 256
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgWe,
  input  logic [$clog2(NUM_BANKS)-1:0] cfgSel,
  input  logic [CFG_W-1:0]             cfgWdata,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic                         reqWrite,
  input  logic                         reqBurst,
  input  logic [ADDR_W-3:0]            reqAddr,
  input  logic [3:0]                   reqBe,
  input  logic [31:0]                  reqWdata,
  output logic                         rspValid,
  output logic                         rspErr,
  output logic                         rspLast,
  output logic [31:0]                  rspData,
  output logic [NUM_BANKS-1:0]         busCs,
  output logic                         busOe,
  output logic                         busWe,
  output logic [3:0]                   busBe,
  output logic [ADDR_W-1:0]            busAddr,
  output logic [31:0]                  busDout,
  input  logic [31:0]                  busDin,
  input  logic                         busReady
);
  dpCtl_t dpCtl;

  extbus_ctl #(.NUM_BANKS(NUM_BANKS), .TIMEOUT(TIMEOUT)) ctl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqBurst(reqBurst),
    .reqWin(reqAddr[ADDR_W-3 -: WIN_W]), .busReady(busReady),
    .reqReady(reqReady), .rspValid(rspValid), .rspErr(rspErr), .rspLast(rspLast),
    .busCs(busCs), .busOe(busOe), .busWe(busWe), .dpCtl(dpCtl)
  );

  extbus_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .reqAddr(reqAddr), .reqBe(reqBe),
    .reqWdata(reqWdata), .busDin(busDin), .busAddr(busAddr), .busBe(busBe),
    .busDout(busDout), .rspData(rspData)
  );
endmodule

// File: rtl/extbus_chk.sv
module extbus_chk #(
  parameter int ADDR_W    = 27,
  parameter int NUM_BANKS = 8,
  parameter int TIMEOUT   = 256
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic                 rspValid,
  input logic                 rspErr,
  input logic                 rspLast,
  input logic [NUM_BANKS-1:0] busCs,
  input logic                 busOe,
  input logic                 busWe,
  input logic [ADDR_W-1:0]    busAddr
);
  logic [15:0]       runLen;
  logic [ADDR_W-1:0] prevAddr;
  logic              prevCs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runLen   <= '0;
      prevAddr <= '0;
      prevCs   <= 1'b0;
    end else begin
      runLen   <= (|busCs && prevCs && busAddr == prevAddr) ? runLen + 1'b1 : '0;
      prevAddr <= busAddr;
      prevCs   <= |busCs;
    end
  end

  AST_CS_ONEHOT:     assert property (@(posedge clk) disable iff (!rstN) $onehot0(busCs));               // R1
  AST_ERR_IS_LAST:   assert property (@(posedge clk) disable iff (!rstN) rspErr |-> (rspValid && rspLast)); // R2
  AST_STROBE_BOUND:  assert property (@(posedge clk) disable iff (!rstN) runLen < 16'(TIMEOUT));         // R4
  AST_OE_WE_EXCL:    assert property (@(posedge clk) disable iff (!rstN) !(busOe && busWe));             // R9
  AST_STROBE_HAS_CS: assert property (@(posedge clk) disable iff (!rstN) (busOe || busWe) |-> (|busCs)); // R9
  AST_IDLE_NO_CS:    assert property (@(posedge clk) disable iff (!rstN) reqReady |-> (busCs == '0));    // R10
  AST_ACCEPT_MOVES:  assert property (@(posedge clk) disable iff (!rstN)
                       (reqValid && reqReady) |=> (!reqReady || (rspValid && rspErr)));                 // R10
endmodule

bind extbus_ctrl extbus_chk #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .TIMEOUT(TIMEOUT)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .rspValid(rspValid),
  .rspErr(rspErr), .rspLast(rspLast), .busCs(busCs), .busOe(busOe), .busWe(busWe), .busAddr(busAddr)
);

// File: tb/extbus_ctrl_tb_top.sv
`timescale 1ns/1ps
module extbus_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [22:0] cfgWdata = '0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqBurst = 1'b0;
  logic [24:0] reqAddr = '0;
  logic [3:0]  reqBe = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, rspValid, rspErr, rspLast, busOe, busWe, busReady;
  logic [31:0] rspData, busDout, busDin;
  logic [7:0]  busCs;
  logic [3:0]  busBe;
  logic [26:0] busAddr;

  always #10 clk = ~clk;

  extbus_ctrl dut_i (.*);

  // Device model: data derived from address, ready after readyDelay strobe cycles.
  int readyDelay = 0;
  int rdyCnt = 0;
  assign busDin   = {~busAddr[15:0], busAddr[15:0]};
  assign busReady = (|busCs) && (rdyCnt == readyDelay);
  always @(posedge clk) rdyCnt <= (|busCs && !busReady) ? rdyCnt + 1 : 0;

  int errors = 0, checks = 0;
  int strobes, lat, nRsp, nAddr;
  logic [7:0]  csSeen;
  logic        oeSeen, weSeen, bothBad, readyBad;
  logic [31:0] rdata [16];
  logic        rerr [16];
  logic        rlast [16];
  logic [26:0] addrSeq [32];
  logic [3:0]  firstBe;
  logic [31:0] firstDout;

  function automatic logic [31:0] dev(input logic [26:0] a);
    return {~a[15:0], a[15:0]};
  endfunction

  function automatic logic [22:0] mkCfg(input logic en, wide, paced, crit,
                                        input logic [3:0] waits, input logic [6:0] base, mask);
    return {mask, 1'b0, base, waits, crit, paced, wide, en};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setCfg(input int idx, input logic [22:0] w);
    @(negedge clk); cfgWe = 1'b1; cfgSel = 3'(idx); cfgWdata = w;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic runReq(input logic w, b, input logic [26:0] a, input logic [3:0] be, input logic [31:0] wd);
    logic [26:0] prevA;
    logic prevCs;
    strobes = 0; lat = 0; nRsp = 0; nAddr = 0; csSeen = '0;
    oeSeen = 0; weSeen = 0; prevCs = 0; prevA = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqBurst = b; reqAddr = a[26:2]; reqBe = be; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    for (int cyc = 1; cyc < 600; cyc++) begin
      if (|busCs) begin
        strobes++;
        csSeen |= busCs;
        oeSeen |= busOe;
        weSeen |= busWe;
        if (busOe && busWe) bothBad = 1'b1;
        if (reqReady) readyBad = 1'b1;
        if (!prevCs || busAddr != prevA) begin
          if (nAddr == 0) begin firstBe = busBe; firstDout = busDout; end
          if (nAddr < 32) addrSeq[nAddr] = busAddr;
          nAddr++;
        end
      end
      prevCs = |busCs;
      prevA  = busAddr;
      if (rspValid) begin
        if (nRsp == 0) lat = cyc;
        if (nRsp < 16) begin rdata[nRsp] = rspData; rerr[nRsp] = rspErr; rlast[nRsp] = rspLast; end
        nRsp++;
        if (rspLast) break;
      end
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic [26:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic        narrow;
    logic [7:0]  cs;
    logic [7:0]  strb;
    logic        err;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{1'b0, 27'h0000040, 4'hF, 32'h0000_0000, 1'b0, 8'h01, 8'd3, 1'b0},
    '{1'b1, 27'h0000080, 4'h6, 32'hCAFE_F00D, 1'b0, 8'h01, 8'd3, 1'b0},
    '{1'b0, 27'h0100010, 4'hF, 32'h0000_0000, 1'b1, 8'h02, 8'd2, 1'b0},
    '{1'b1, 27'h0100020, 4'h9, 32'h1234_ABCD, 1'b1, 8'h02, 8'd2, 1'b0},
    '{1'b0, 27'h1800000, 4'hF, 32'h0000_0000, 1'b0, 8'h08, 8'd1, 1'b0},
    '{1'b0, 27'h1000004, 4'hF, 32'h0000_0000, 1'b0, 8'h08, 8'd1, 1'b0},
    '{1'b0, 27'h3000000, 4'hF, 32'h0000_0000, 1'b0, 8'h00, 8'd0, 1'b1},
    '{1'b0, 27'h7F00000, 4'hF, 32'h0000_0000, 1'b0, 8'h00, 8'd0, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    bothBad = 0; readyBad = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 reset reqReady", 32'(reqReady), 32'd1);
    chk("R1 reset busCs", 32'(busCs), 32'd0);
    chk("R2 reset rspValid", 32'(rspValid), 32'd0);

    setCfg(0, mkCfg(1, 1, 0, 0, 4'd2, 7'h00, 7'h7F));
    setCfg(1, mkCfg(1, 0, 0, 0, 4'd0, 7'h01, 7'h7F));
    setCfg(2, mkCfg(1, 1, 1, 0, 4'd0, 7'h02, 7'h7E));
    setCfg(3, mkCfg(1, 1, 0, 1, 4'd0, 7'h10, 7'h70));
    setCfg(4, mkCfg(1, 1, 0, 0, 4'd0, 7'h20, 7'h7F));
    setCfg(5, mkCfg(1, 1, 0, 0, 4'd1, 7'h10, 7'h7F));
    setCfg(6, mkCfg(0, 1, 0, 0, 4'd0, 7'h30, 7'h7F));

    foreach (VEC[i]) begin
      runReq(VEC[i].wr, 1'b0, VEC[i].addr, VEC[i].be, VEC[i].wd);
      chk($sformatf("R1 vec%0d chip select", i), 32'(csSeen), 32'(VEC[i].cs));
      chk($sformatf("R2 vec%0d error", i), 32'(rerr[0]), 32'(VEC[i].err));
      chk($sformatf("R3 vec%0d strobe cycles", i), 32'(strobes), 32'(VEC[i].strb));
      chk($sformatf("R3 vec%0d latency", i), 32'(lat), 32'(VEC[i].strb) + 1);
      chk($sformatf("R10 vec%0d single response", i), 32'(nRsp), 32'd1);
      if (!VEC[i].err) begin
        chk($sformatf("R9 vec%0d enables", i), {30'd0, oeSeen, weSeen}, {30'd0, !VEC[i].wr, VEC[i].wr});
        if (VEC[i].narrow) begin
          chk($sformatf("R5 vec%0d low half addr", i), 32'(addrSeq[0]), 32'(VEC[i].addr & ~27'd3));
          chk($sformatf("R5 vec%0d high half addr", i), 32'(addrSeq[1]), 32'(VEC[i].addr | 27'd2));
        end
        if (VEC[i].wr && VEC[i].narrow) begin
          chk($sformatf("R5 vec%0d first be", i), 32'(firstBe), {30'd0, VEC[i].be[1:0]});
          chk($sformatf("R5 vec%0d first dout", i), firstDout, {16'd0, VEC[i].wd[15:0]});
        end else if (VEC[i].wr) begin
          chk($sformatf("R6 vec%0d be", i), 32'(firstBe), 32'(VEC[i].be));
          chk($sformatf("R6 vec%0d dout", i), firstDout, VEC[i].wd);
        end else if (VEC[i].narrow) begin
          chk($sformatf("R5 vec%0d merged data", i), rdata[0],
              {dev(VEC[i].addr | 27'd2) & 32'h0000FFFF} << 16 | (dev(VEC[i].addr & ~27'd3) & 32'h0000FFFF));
        end else begin
          chk($sformatf("R6 vec%0d read data", i), rdata[0], dev(VEC[i].addr));
        end
      end
    end

    // R4 paced transfers
    readyDelay = 3;
    runReq(1'b0, 1'b0, 27'h0200008, 4'hF, 32'h0);
    chk("R4 paced strobe cycles", 32'(strobes), 32'd4);
    chk("R4 paced data", rdata[0], dev(27'h0200008));
    readyDelay = 0;
    runReq(1'b0, 1'b0, 27'h03FFFFC, 4'hF, 32'h0);
    chk("R1 masked window hit", 32'(csSeen), 32'h04);
    chk("R4 immediate ready", 32'(strobes), 32'd1);
    readyDelay = 1000;
    runReq(1'b0, 1'b0, 27'h0200000, 4'hF, 32'h0);
    chk("R4 timeout strobe cycles", 32'(strobes), 32'd256);
    chk("R4 timeout error", {30'd0, rerr[0], rlast[0]}, 32'd3);
    readyDelay = 0;

    // R7 sequential line fill
    runReq(1'b0, 1'b1, 27'h2000018, 4'hF, 32'h0);
    chk("R7 beat count", 32'(nRsp), 32'd8);
    for (int k = 0; k < 8; k++) begin
      chk($sformatf("R7 beat %0d data", k), rdata[k], dev(27'h2000000 + 27'(4 * k)));
      chk($sformatf("R7 beat %0d last", k), 32'(rlast[k]), 32'(k == 7));
    end

    // R8 critical-word-first fill, wraps after word 7
    runReq(1'b0, 1'b1, 27'h1000014, 4'hF, 32'h0);
    chk("R8 beat count", 32'(nRsp), 32'd8);
    for (int k = 0; k < 8; k++)
      chk($sformatf("R8 beat %0d data", k), rdata[k], dev(27'h1000000 + 27'(4 * ((5 + k) % 8))));

    // R7 burst flag on a write gives a single transfer
    runReq(1'b1, 1'b1, 27'h2000008, 4'hF, 32'h5555_AAAA);
    chk("R7 burst write responses", 32'(nRsp), 32'd1);
    chk("R7 burst write strobes", 32'(strobes), 32'd1);

    // R1 enabling a bank through the configuration port
    setCfg(6, mkCfg(1, 1, 0, 0, 4'd0, 7'h30, 7'h7F));
    runReq(1'b0, 1'b0, 27'h3000000, 4'hF, 32'h0);
    chk("R1 newly enabled bank", 32'(csSeen), 32'h40);
    chk("R2 newly enabled bank no error", 32'(rerr[0]), 32'd0);

    chk("R9 OE and WE never together", 32'(bothBad), 32'd0);
    chk("R10 reqReady low while busy", 32'(readyBad), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule